// File: doc/BRIEF.md
# Two-Port Word Memory with Byte-Lane Control

This block is a clocked memory of 16-bit words that two masters, called the left port and the right port, can reach at the same time. Each port carries its own chip select, write select, output enable, upper-lane and lower-lane enables, a flag-select override, an address, a write-data bus and a read-data bus. All controls are active-low and are sampled on the rising edge of one shared clock. Each port decodes its controls into one of four modes: idle, write, read, or muted read. In a write, only the enabled byte lanes are stored. In a read, only the enabled lanes are returned.

There are no tri-state drivers. Each port instead has a two-bit lane-valid flag, where bit 1 covers bits 15:8 and bit 0 covers bits 7:0. A lane whose flag is low returns zero on the read bus. Read data and flags appear one cycle after the address is sampled. If both ports write the same word in the same cycle, the left port wins on every lane it writes. The right port still lands on any lane the left port leaves alone. A read that meets a write to the same word from the other port in the same cycle returns the word as it was before that write.

The address width is a parameter. The default of 11 bits gives 2048 words, and 13 bits gives the full 8192-word by 16-bit configuration.

Top module: `dpr_bytelane`

## Requirements
- R1: The array holds 2**ADDR_W words of 16 bits, and every word can be written and read back through either port.
- R2: The two ports work independently in the same cycle, including both reading the same word.
- R3: A port with chip select high, or with both lane enables high, neither writes nor returns data. Its lane-valid flags are 00 in the next cycle.
- R4: A write (chip select low, write select low, flag select high) stores bits 15:8 only if the upper enable is low, and stores bits 7:0 only if the lower enable is low.
- R5: A read (chip select low, write select high, output enable low, flag select high) sets lane-valid bit 1 for an enabled upper lane and bit 0 for an enabled lower lane. These flags and the stored data appear one cycle after the address is sampled. After any cycle that is not a read, the flags are 00.
- R6: With output enable high, a read sets no lane-valid flag and returns zero.
- R7: With flag select low, the port neither writes nor reads the array.
- R8: If both ports write the same word in one cycle, each lane that the left port writes takes the left data. A lane written only by the right port takes the right data.
- R9: A read-data lane whose valid flag is low reads as zero.
- R10: A read that meets a write to the same word from the other port in the same cycle returns the previous contents.
- R11: While reset is low, at each clock edge both ports' lane-valid flags and read data are cleared to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lp_cs_n | input | 1 | Left chip select, active low |
| lp_wr_n | input | 1 | Left write select, low = write, high = read |
| lp_oe_n | input | 1 | Left output enable, active low |
| lp_hi_n | input | 1 | Left upper-lane enable (bits 15:8), active low |
| lp_lo_n | input | 1 | Left lower-lane enable (bits 7:0), active low |
| lp_sem_n | input | 1 | Left flag select, low blocks array access |
| lp_addr | input | ADDR_W | Left word address |
| lp_wdata | input | 16 | Left write data |
| lp_rdata | output | 16 | Left read data, zero in lanes that are not valid |
| lp_rvalid | output | 2 | Left lane-valid flags, bit 1 = upper, bit 0 = lower |
| rp_cs_n | input | 1 | Right chip select, active low |
| rp_wr_n | input | 1 | Right write select, low = write, high = read |
| rp_oe_n | input | 1 | Right output enable, active low |
| rp_hi_n | input | 1 | Right upper-lane enable, active low |
| rp_lo_n | input | 1 | Right lower-lane enable, active low |
| rp_sem_n | input | 1 | Right flag select, low blocks array access |
| rp_addr | input | ADDR_W | Right word address |
| rp_wdata | input | 16 | Right write data |
| rp_rdata | output | 16 | Right read data, zero in lanes that are not valid |
| rp_rvalid | output | 2 | Right lane-valid flags |

## Verification
- **Full fill:** both ports fill the whole array and read it back. This separates a working address path from a stuck or aliased one.
- **Directed single-lane cases:** single-lane writes and reads on each port tell a correct lane mapping from swapped or merged lanes.
- **Blocked cases:** deselect, both-lanes-off, output-disabled and flag-select cycles are each followed by a read-back. This shows that the blocked access neither wrote the array nor raised a flag.
- **Collisions:** same-word writes from both ports, with full and with split lane masks, check left-over-right priority lane by lane. A write on one port paired with a read on the other shows the read-before-write ordering.
- **Random traffic:** a long run with random controls over a small address window compares every cycle against a behavioural model, so collisions arise often.

// File: rtl/dpr_pkg.sv
// Package: shared constants and types for the two-port byte-lane memory.
// Assumes every word is split into exactly two byte lanes (upper, lower).
package dpr_pkg;

    // Number of byte lanes per word; lane 1 = upper, lane 0 = lower.
    localparam int LANES = 2;

    // Decoded access mode of one port in one cycle.
    typedef enum logic [1:0] {
        ACC_IDLE  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_READ  = 2'd2,
        ACC_MUTED = 2'd3
    } acc_mode_e;

endpackage

// File: rtl/dpr_port_decode.sv
// Module: per-port control decoder.
// Turns the active-low controls of one port into per-lane write and read
// strobes. The flag-select override, the chip select and the lane enables
// gate everything; the output enable gates only reads.
// Assumes: purely combinational; clk/rst_n feed only the assertions.
module dpr_port_decode
    import dpr_pkg::*;
#(
    parameter int NLANE = LANES
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_n,
    input  logic             wr_n,
    input  logic             oe_n,
    input  logic             sel_n,
    input  logic [NLANE-1:0] lane_n,
    output logic [NLANE-1:0] wr_lanes,
    output logic [NLANE-1:0] rd_lanes
);

    acc_mode_e        mode;
    logic [NLANE-1:0] lane_on;

    // Purpose: classify this cycle's access from the control pins.
    always_comb begin
        lane_on = ~lane_n;
        mode    = ACC_IDLE;
        if (!cs_n && sel_n && (|lane_on)) begin
            if (!wr_n)      mode = ACC_WRITE;
            else if (!oe_n) mode = ACC_READ;
            else            mode = ACC_MUTED;
        end
    end

    // Purpose: steer the enabled lanes to the strobe that matches the mode.
    always_comb begin
        wr_lanes = '0;
        rd_lanes = '0;
        case (mode)
            ACC_WRITE: wr_lanes = lane_on;
            ACC_READ:  rd_lanes = lane_on;
            default: begin
                wr_lanes = '0;
                rd_lanes = '0;
            end
        endcase
    end

    // A deselected port raises no strobe (R3).
    assert_deselect_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n || (&lane_n)) |-> (wr_lanes == '0 && rd_lanes == '0));

    // Flag select low blocks the array (R7).
    assert_flag_sel_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_n |-> (wr_lanes == '0 && rd_lanes == '0));

    // No read strobe without output enable (R6).
    assert_read_needs_oe_R6: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> (rd_lanes == '0));

    // Write strobes only on enabled lanes, never together with reads (R4).
    assert_write_lanes_subset_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_lanes != '0) |-> (((wr_lanes & lane_n) == '0) && (rd_lanes == '0)));

endmodule

// File: rtl/dpr_lane_bank.sv
// Module: storage for one byte lane of every word, with two ports.
// Reads return the contents from before any write in the same cycle.
// On a same-address write from both ports, the left port wins.
// Assumes: contents are not reset; only the read registers are.
module dpr_lane_bank #(
    parameter int ADDR_W = 11,
    parameter int BYTE_W = 8,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              l_we,
    input  logic              l_re,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic [BYTE_W-1:0] l_wd,
    output logic [BYTE_W-1:0] l_q,
    input  logic              r_we,
    input  logic              r_re,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic [BYTE_W-1:0] r_wd,
    output logic [BYTE_W-1:0] r_q
);

    logic [BYTE_W-1:0] mem [DEPTH];

    // Purpose: store writes; the left write is issued last so it wins.
    always_ff @(posedge clk) begin
        if (r_we) mem[r_addr] <= r_wd;
        if (l_we) mem[l_addr] <= l_wd;
    end

    // Purpose: capture the pre-write contents for each reading port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            l_q <= '0;
            r_q <= '0;
        end else begin
            if (l_re) l_q <= mem[l_addr];
            if (r_re) r_q <= mem[r_addr];
        end
    end

    // Read registers hold when not read (R5).
    assert_left_q_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!l_re && $past(rst_n)) |=> $stable(l_q));
    assert_right_q_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!r_re && $past(rst_n)) |=> $stable(r_q));

endmodule

// File: rtl/dpr_store.sv
// Module: the word array, built from one two-port bank per byte lane.
// Assumes: the lane strobes come from the port decoders; lane g covers
// data bits [g*BYTE_W +: BYTE_W].
module dpr_store
    import dpr_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter int BYTE_W = 8,
    localparam int DATA_W = LANES * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LANES-1:0]  l_wr,
    input  logic [LANES-1:0]  l_rd,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic [DATA_W-1:0] l_wdata,
    output logic [DATA_W-1:0] l_raw,
    input  logic [LANES-1:0]  r_wr,
    input  logic [LANES-1:0]  r_rd,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic [DATA_W-1:0] r_wdata,
    output logic [DATA_W-1:0] r_raw
);

    // Purpose: one bank per lane, each with its own strobes.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        dpr_lane_bank #(
            .ADDR_W (ADDR_W),
            .BYTE_W (BYTE_W)
        ) u_bank (
            .clk    (clk),
            .rst_n  (rst_n),
            .l_we   (l_wr[g]),
            .l_re   (l_rd[g]),
            .l_addr (l_addr),
            .l_wd   (l_wdata[g*BYTE_W +: BYTE_W]),
            .l_q    (l_raw[g*BYTE_W +: BYTE_W]),
            .r_we   (r_wr[g]),
            .r_re   (r_rd[g]),
            .r_addr (r_addr),
            .r_wd   (r_wdata[g*BYTE_W +: BYTE_W]),
            .r_q    (r_raw[g*BYTE_W +: BYTE_W])
        );
    end

endmodule

// File: rtl/dpr_bytelane.sv
// Module: top of the two-port byte-lane memory.
// Decodes both ports, drives the shared array, registers the per-lane
// valid flags and zeroes every read lane that is not valid.
// Assumes: all controls are active-low and synchronous to clk.
module dpr_bytelane
    import dpr_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter int BYTE_W = 8,
    localparam int DATA_W = LANES * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lp_cs_n,
    input  logic              lp_wr_n,
    input  logic              lp_oe_n,
    input  logic              lp_hi_n,
    input  logic              lp_lo_n,
    input  logic              lp_sem_n,
    input  logic [ADDR_W-1:0] lp_addr,
    input  logic [DATA_W-1:0] lp_wdata,
    output logic [DATA_W-1:0] lp_rdata,
    output logic [LANES-1:0]  lp_rvalid,
    input  logic              rp_cs_n,
    input  logic              rp_wr_n,
    input  logic              rp_oe_n,
    input  logic              rp_hi_n,
    input  logic              rp_lo_n,
    input  logic              rp_sem_n,
    input  logic [ADDR_W-1:0] rp_addr,
    input  logic [DATA_W-1:0] rp_wdata,
    output logic [DATA_W-1:0] rp_rdata,
    output logic [LANES-1:0]  rp_rvalid
);

    logic [LANES-1:0]  l_wr, l_rd, r_wr, r_rd;
    logic [DATA_W-1:0] l_raw, r_raw;

    dpr_port_decode #(.NLANE(LANES)) u_dec_l (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_n     (lp_cs_n),
        .wr_n     (lp_wr_n),
        .oe_n     (lp_oe_n),
        .sel_n    (lp_sem_n),
        .lane_n   ({lp_hi_n, lp_lo_n}),
        .wr_lanes (l_wr),
        .rd_lanes (l_rd)
    );

    dpr_port_decode #(.NLANE(LANES)) u_dec_r (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_n     (rp_cs_n),
        .wr_n     (rp_wr_n),
        .oe_n     (rp_oe_n),
        .sel_n    (rp_sem_n),
        .lane_n   ({rp_hi_n, rp_lo_n}),
        .wr_lanes (r_wr),
        .rd_lanes (r_rd)
    );

    dpr_store #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .l_wr    (l_wr),
        .l_rd    (l_rd),
        .l_addr  (lp_addr),
        .l_wdata (lp_wdata),
        .l_raw   (l_raw),
        .r_wr    (r_wr),
        .r_rd    (r_rd),
        .r_addr  (rp_addr),
        .r_wdata (rp_wdata),
        .r_raw   (r_raw)
    );

    // Purpose: register which lanes each port read in the previous cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lp_rvalid <= '0;
            rp_rvalid <= '0;
        end else begin
            lp_rvalid <= l_rd;
            rp_rvalid <= r_rd;
        end
    end

    // Purpose: zero every read lane whose valid flag is low.
    for (genvar g = 0; g < LANES; g++) begin : g_mask
        assign lp_rdata[g*BYTE_W +: BYTE_W] = lp_rvalid[g] ? l_raw[g*BYTE_W +: BYTE_W] : '0;
        assign rp_rdata[g*BYTE_W +: BYTE_W] = rp_rvalid[g] ? r_raw[g*BYTE_W +: BYTE_W] : '0;
    end

    // An enabled upper-lane read raises the upper flag one cycle later (R5).
    assert_left_upper_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!lp_cs_n && lp_sem_n && lp_wr_n && !lp_oe_n && !lp_hi_n) |=> lp_rvalid[1]);
    assert_right_lower_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!rp_cs_n && rp_sem_n && rp_wr_n && !rp_oe_n && !rp_lo_n) |=> rp_rvalid[0]);

    // A write cycle leaves no valid flag behind (R5).
    assert_no_flag_after_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!lp_wr_n && !rp_wr_n) |=> (lp_rvalid == '0 && rp_rvalid == '0));

    // Reset clears the flags and the read data (R11).
    assert_reset_clears_R11: assert property (@(posedge clk)
        !rst_n |=> (lp_rvalid == '0 && rp_rvalid == '0 && lp_rdata == '0 && rp_rdata == '0));

endmodule

// File: tb/dpr_bytelane_tb.sv
// Bench: behavioural model of the two-port memory, compared every cycle.
module dpr_bytelane_tb;

    localparam int AW    = 11;
    localparam int DEPTH = 1 << AW;

    logic clk = 1'b0;
    logic rst_n;
    always #10 clk = ~clk;

    // Bench-side port controls, index 0 = left, 1 = right.
    logic          cs_n [2];
    logic          wr_n [2];
    logic          oe_n [2];
    logic          hi_n [2];
    logic          lo_n [2];
    logic          sm_n [2];
    logic [AW-1:0] addr [2];
    logic [15:0]   wd   [2];
    logic [15:0]   lrd, rrd;
    logic [1:0]    lvl, rvl;

    logic [15:0] model [DEPTH];
    int checks = 0;
    int errors = 0;
    bit done   = 0;

    dpr_bytelane #(.ADDR_W(AW), .BYTE_W(8)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .lp_cs_n(cs_n[0]), .lp_wr_n(wr_n[0]), .lp_oe_n(oe_n[0]),
        .lp_hi_n(hi_n[0]), .lp_lo_n(lo_n[0]), .lp_sem_n(sm_n[0]),
        .lp_addr(addr[0]), .lp_wdata(wd[0]), .lp_rdata(lrd), .lp_rvalid(lvl),
        .rp_cs_n(cs_n[1]), .rp_wr_n(wr_n[1]), .rp_oe_n(oe_n[1]),
        .rp_hi_n(hi_n[1]), .rp_lo_n(lo_n[1]), .rp_sem_n(sm_n[1]),
        .rp_addr(addr[1]), .rp_wdata(wd[1]), .rp_rdata(rrd), .rp_rvalid(rvl)
    );

    task automatic idle(input int p);
        cs_n[p] = 1; wr_n[p] = 1; oe_n[p] = 1; hi_n[p] = 1; lo_n[p] = 1;
        sm_n[p] = 1; addr[p] = '0; wd[p] = '0;
    endtask

    // Controls are given as active-low pin values.
    task automatic drive(input int p, input bit c, input bit w, input bit o,
                         input bit h, input bit l, input bit s,
                         input int a, input logic [15:0] d);
        cs_n[p] = c; wr_n[p] = w; oe_n[p] = o; hi_n[p] = h; lo_n[p] = l;
        sm_n[p] = s; addr[p] = AW'(a); wd[p] = d;
    endtask

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // One clock: compare the outputs caused by the applied inputs, then update the model.
    task automatic step(input string tag);
        logic [1:0]  ev [2];
        logic [15:0] ed [2];
        @(posedge clk);
        @(negedge clk);
        for (int p = 0; p < 2; p++) begin
            bit acc;
            acc = !cs_n[p] && sm_n[p] && !(hi_n[p] && lo_n[p]);
            ev[p] = (acc && wr_n[p] && !oe_n[p]) ? {!hi_n[p], !lo_n[p]} : 2'b00;
            ed[p] = {ev[p][1] ? model[addr[p]][15:8] : 8'h00,
                     ev[p][0] ? model[addr[p]][7:0]  : 8'h00};
        end
        check(tag, "left valid",  32'(lvl), 32'(ev[0]));
        check(tag, "left data",   32'(lrd), 32'(ed[0]));
        check(tag, "right valid", 32'(rvl), 32'(ev[1]));
        check(tag, "right data",  32'(rrd), 32'(ed[1]));
        // Right first, then left, so the left lanes win on a same-word write.
        for (int p = 1; p >= 0; p--) begin
            if (!cs_n[p] && sm_n[p] && !wr_n[p]) begin
                if (!hi_n[p]) model[addr[p]][15:8] = wd[p][15:8];
                if (!lo_n[p]) model[addr[p]][7:0]  = wd[p][7:0];
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 0;
        idle(0); idle(1);
        // R11: a read requested during reset still leaves the outputs cleared.
        drive(0, 0, 1, 0, 0, 0, 1, 0, 0);
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R11", "left valid in reset",  32'(lvl), 0);
        check("R11", "left data in reset",   32'(lrd), 0);
        check("R11", "right valid in reset", 32'(rvl), 0);
        rst_n = 1;
        idle(0);
        step("R11");

        // R1: fill every word, even addresses from the left, odd from the right.
        for (int a = 0; a < DEPTH; a += 2) begin
            drive(0, 0, 0, 1, 0, 0, 1, a,     16'(a * 37 + 5));
            drive(1, 0, 0, 1, 0, 0, 1, a + 1, 16'((a + 1) * 91 + 3));
            step("R1");
        end
        for (int a = 0; a < DEPTH; a += 2) begin
            drive(0, 0, 1, 0, 0, 0, 1, a + 1, 0);
            drive(1, 0, 1, 0, 0, 0, 1, a,     0);
            step("R1");
        end

        // R2: both ports read the same word.
        drive(0, 0, 1, 0, 0, 0, 1, 5, 0); drive(1, 0, 1, 0, 0, 0, 1, 5, 0); step("R2");

        // R4: upper-only write from the left, lower-only write from the right, read back.
        drive(0, 0, 0, 1, 0, 1, 1, 7, 16'hAB12); drive(1, 0, 0, 1, 1, 0, 1, 8, 16'h34CD); step("R4");
        drive(0, 0, 1, 0, 0, 0, 1, 8, 0); drive(1, 0, 1, 0, 0, 0, 1, 7, 0); step("R4");

        // R3: writes with chip select off or both lanes off, then read back.
        drive(0, 1, 0, 1, 0, 0, 1, 20, 16'hDEAD); drive(1, 0, 0, 1, 1, 1, 1, 21, 16'hBEEF); step("R3");
        drive(0, 0, 1, 0, 1, 1, 1, 20, 0); drive(1, 1, 1, 0, 0, 0, 1, 21, 0); step("R3");
        drive(0, 0, 1, 0, 0, 0, 1, 20, 0); drive(1, 0, 1, 0, 0, 0, 1, 21, 0); step("R3");

        // R6: read with output enable off.
        drive(0, 0, 1, 1, 0, 0, 1, 30, 0); drive(1, 0, 1, 1, 0, 1, 1, 31, 0); step("R6");

        // R7: flag select low blocks a write and a read, then read back.
        drive(0, 0, 0, 1, 0, 0, 0, 40, 16'h5555); drive(1, 0, 1, 0, 0, 0, 0, 40, 0); step("R7");
        drive(0, 0, 1, 0, 0, 0, 1, 40, 0); idle(1); step("R7");

        // R9 and R5: single-lane reads zero the other lane.
        drive(0, 0, 1, 0, 0, 1, 1, 50, 0); drive(1, 0, 1, 0, 1, 0, 1, 50, 0); step("R9");

        // R8: full same-word collision, then split lanes, then read back.
        drive(0, 0, 0, 1, 0, 0, 1, 9, 16'h1111); drive(1, 0, 0, 1, 0, 0, 1, 9, 16'h2222); step("R8");
        drive(0, 0, 0, 1, 0, 1, 1, 10, 16'hAAAA); drive(1, 0, 0, 1, 0, 0, 1, 10, 16'hBBBB); step("R8");
        drive(0, 0, 1, 0, 0, 0, 1, 9, 0); drive(1, 0, 1, 0, 0, 0, 1, 10, 0); step("R8");

        // R10: right reads the word the left writes in the same cycle, then again.
        drive(0, 0, 0, 1, 0, 0, 1, 12, 16'hC0DE); drive(1, 0, 1, 0, 0, 0, 1, 12, 0); step("R10");
        idle(0); step("R10");

        // R2: random traffic over a small window to provoke collisions.
        for (int i = 0; i < 4000; i++) begin
            for (int p = 0; p < 2; p++) begin
                drive(p, ($urandom % 8) == 0, $urandom % 2, ($urandom % 6) == 0,
                      $urandom % 2, $urandom % 2, ($urandom % 10) != 0,
                      $urandom % 16, 16'($urandom));
            end
            step("R2");
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule